// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Acceptance Unit

This block decides, for a simple in-order core, whether an interrupt is taken at an instruction boundary and which vector goes with it. Two kinds of request come in. Maskable requests arrive as a valid/ready stream that carries a vector. Non-maskable requests arrive either as a rising edge on an asynchronous pin or as a one-cycle message on a system bus port whose delivery-mode field selects the non-maskable kind. The retirement stage reports each retired step. A step can be an interior micro-step, the end of an instruction, or the end of one iteration of a repeat-prefixed instruction that has further iterations to run.

When the block accepts an interrupt, it raises a one-cycle take strobe. The strobe carries the vector and the return pointer that the core must save. The block keeps the interrupt-enable flag, which software sets and clears through strobes. It also keeps a blocking state that starts when a non-maskable interrupt is taken and ends when the core signals that the handler has returned.

Maskable request stream rules: the source raises `irq_valid` and holds `irq_vector` stable until `irq_ready` is seen high in the same cycle. `irq_ready` is high only in a boundary cycle where the request wins. A request that loses stays pending, and the source keeps it asserted. The block never drops a request by itself.

Top module: `intr_accept_unit`

## Requirements
- R1: A non-maskable request is recorded on a rising edge of `nmi_pin`, seen after two synchroniser flops, or by a cycle with `bus_msg_valid` high and `bus_msg_mode` equal to 3'b100. A bus message with any other mode value is ignored.
- R2: An accepted non-maskable interrupt delivers vector 8'd2 on `take_vector`.
- R3: A maskable request is accepted only while `if_flag` is 1, and it delivers its own `irq_vector`. `if_set` sets the flag and `if_clr` clears it, with the clear winning when both are high. A change takes effect in the following cycle. The flag has no effect on non-maskable requests.
- R4: After a non-maskable interrupt is accepted, `nmi_blocked` is 1. No interrupt of either kind is accepted until `nmi_done` is seen, and `nmi_blocked` is 0 in the cycle after `nmi_done`.
- R5: An interrupt is accepted only in a cycle with `ret_valid` and `ret_boundary` both high. A retirement with `ret_boundary` low never causes a take.
- R6: The return pointer is `ret_ip` when `ret_rep` is 1, which resumes the next iteration of the same instruction. Otherwise it is `ret_next_ip`.
- R7: Non-maskable events that arrive while blocked are held as a single pending request. That request is delivered at the first boundary after blocking ends, and it is delivered only once however many events arrived.
- R8: When both kinds are pending at one boundary, the non-maskable one is taken, `irq_ready` stays low, and the maskable request remains pending.
- R9: `irq_ready` is high in the boundary cycle of acceptance. `take` is high for exactly the next cycle, together with `take_vector` and `take_ret_ip`.
- R10: After reset, `if_flag` is 0, nothing is pending, `nmi_blocked` is 0 and `take` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_valid | input | 1 | Maskable request valid |
| irq_vector | input | 8 | Maskable request vector |
| irq_ready | output | 1 | Maskable request accepted this cycle |
| nmi_pin | input | 1 | Asynchronous non-maskable request pin |
| bus_msg_valid | input | 1 | Bus interrupt message strobe |
| bus_msg_mode | input | 3 | Bus message delivery mode |
| if_set | input | 1 | Set interrupt-enable flag |
| if_clr | input | 1 | Clear interrupt-enable flag |
| ret_valid | input | 1 | A step retired this cycle |
| ret_boundary | input | 1 | Retired step ends an instruction or an iteration |
| ret_rep | input | 1 | Boundary is the end of a repeat iteration with more to run |
| ret_ip | input | 32 | Address of the retiring instruction |
| ret_next_ip | input | 32 | Address of the following instruction |
| nmi_done | input | 1 | Non-maskable handler has returned |
| take | output | 1 | Interrupt taken strobe |
| take_vector | output | 8 | Vector of the taken interrupt |
| take_ret_ip | output | 32 | Return pointer to be saved |
| if_flag | output | 1 | Current interrupt-enable flag |
| nmi_blocked | output | 1 | Non-maskable blocking active |

## Verification
The acceptance decision is driven from a vector table that varies the enable flag, the kind of boundary and the request vector. This shows whether gating, vector passing and the choice of return pointer interact correctly. Directed cases then exercise the pin path with the flag clear. That case separates non-maskable from maskable gating. Several bus events are sent while blocked, which shows whether they collapse into one pending request. A boundary with both kinds pending shows which one wins and whether the loser is kept. An interior retirement and a bus message with a non-matching mode show that neither one leads to a take.

// File: rtl/intr_pkg.sv
package intr_pkg;
  localparam int unsigned NMI_VECTOR_DEF = 2;
  localparam int unsigned NMI_MODE_DEF   = 4;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_NMI  = 2'd1,
    SEL_MASK = 2'd2
  } sel_e;
endpackage

// File: rtl/intr_nmi_track.sv
module intr_nmi_track #(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MODE_W      = 3,
  parameter logic [MODE_W-1:0] NMI_MODE = 3'b100
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_pin,
  input  logic              bus_valid,
  input  logic [MODE_W-1:0] bus_mode,
  input  logic              nmi_accept,
  input  logic              nmi_done,
  output logic              nmi_pending,
  output logic              nmi_blocked
);
  logic [SYNC_STAGES:0] chain_q;
  logic pin_rise, bus_hit, set_pend;

  always_ff @(posedge clk) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[SYNC_STAGES-1:0], nmi_pin};
  end

  assign pin_rise = chain_q[SYNC_STAGES-1] & ~chain_q[SYNC_STAGES];
  assign bus_hit  = bus_valid && (bus_mode == NMI_MODE);
  assign set_pend = pin_rise | bus_hit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nmi_pending <= 1'b0;
      nmi_blocked <= 1'b0;
    end else begin
      if (set_pend)        nmi_pending <= 1'b1;
      else if (nmi_accept) nmi_pending <= 1'b0;
      if (nmi_accept)      nmi_blocked <= 1'b1;
      else if (nmi_done)   nmi_blocked <= 1'b0;
    end
  end

  // R7: a request held during blocking is not lost
  p_pend_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pending && nmi_blocked |=> nmi_pending);
endmodule

// File: rtl/intr_if_flag.sv
module intr_if_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic if_set,
  input  logic if_clr,
  output logic if_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)      if_flag <= 1'b0;
    else if (if_clr) if_flag <= 1'b0;
    else if (if_set) if_flag <= 1'b1;
  end

  // R3: clear wins over set
  p_clr_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    if_clr |=> !if_flag);
endmodule

// File: rtl/intr_arbiter.sv
module intr_arbiter
  import intr_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned VEC_W  = 8,
  parameter int unsigned NMI_VECTOR = NMI_VECTOR_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ret_valid,
  input  logic              ret_boundary,
  input  logic              ret_rep,
  input  logic [ADDR_W-1:0] ret_ip,
  input  logic [ADDR_W-1:0] ret_next_ip,
  input  logic              nmi_pending,
  input  logic              nmi_blocked,
  input  logic              if_flag,
  input  logic              irq_valid,
  input  logic [VEC_W-1:0]  irq_vector,
  output logic              nmi_accept,
  output logic              irq_ready,
  output logic              take,
  output logic [VEC_W-1:0]  take_vector,
  output logic [ADDR_W-1:0] take_ret_ip
);
  sel_e sel;
  logic at_boundary;

  assign at_boundary = ret_valid && ret_boundary;

  always_comb begin
    sel = SEL_NONE;
    if (at_boundary && !nmi_blocked) begin
      if (nmi_pending)                sel = SEL_NMI;
      else if (irq_valid && if_flag)  sel = SEL_MASK;
    end
  end

  assign nmi_accept = (sel == SEL_NMI);
  assign irq_ready  = (sel == SEL_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take        <= 1'b0;
      take_vector <= '0;
      take_ret_ip <= '0;
    end else begin
      take <= (sel != SEL_NONE);
      if (sel != SEL_NONE) begin
        take_vector <= (sel == SEL_NMI) ? VEC_W'(NMI_VECTOR) : irq_vector;
        take_ret_ip <= ret_rep ? ret_ip : ret_next_ip;
      end
    end
  end

  // R5: a take follows a boundary retirement
  p_only_boundary_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(ret_valid && ret_boundary));
  // R6: repeat iteration resumes at the same instruction
  p_rep_resume_r6: assert property (@(posedge clk) disable iff (!rst_n)
    take && $past(ret_rep) |-> take_ret_ip == $past(ret_ip));
endmodule

// File: rtl/intr_accept_unit.sv
module intr_accept_unit
  import intr_pkg::*;
#(
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned VEC_W       = 8,
  parameter int unsigned MODE_W      = 3,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned NMI_VECTOR  = NMI_VECTOR_DEF,
  parameter int unsigned NMI_MODE    = NMI_MODE_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_valid,
  input  logic [VEC_W-1:0]  irq_vector,
  output logic              irq_ready,
  input  logic              nmi_pin,
  input  logic              bus_msg_valid,
  input  logic [MODE_W-1:0] bus_msg_mode,
  input  logic              if_set,
  input  logic              if_clr,
  input  logic              ret_valid,
  input  logic              ret_boundary,
  input  logic              ret_rep,
  input  logic [ADDR_W-1:0] ret_ip,
  input  logic [ADDR_W-1:0] ret_next_ip,
  input  logic              nmi_done,
  output logic              take,
  output logic [VEC_W-1:0]  take_vector,
  output logic [ADDR_W-1:0] take_ret_ip,
  output logic              if_flag,
  output logic              nmi_blocked
);
  localparam logic [MODE_W-1:0] NMI_MODE_L = MODE_W'(NMI_MODE);

  logic nmi_pending, nmi_accept;

  intr_nmi_track #(
    .SYNC_STAGES(SYNC_STAGES), .MODE_W(MODE_W), .NMI_MODE(NMI_MODE_L)
  ) u_nmi (
    .clk(clk), .rst_n(rst_n), .nmi_pin(nmi_pin),
    .bus_valid(bus_msg_valid), .bus_mode(bus_msg_mode),
    .nmi_accept(nmi_accept), .nmi_done(nmi_done),
    .nmi_pending(nmi_pending), .nmi_blocked(nmi_blocked)
  );

  intr_if_flag u_if (
    .clk(clk), .rst_n(rst_n), .if_set(if_set), .if_clr(if_clr), .if_flag(if_flag)
  );

  intr_arbiter #(
    .ADDR_W(ADDR_W), .VEC_W(VEC_W), .NMI_VECTOR(NMI_VECTOR)
  ) u_arb (
    .clk(clk), .rst_n(rst_n),
    .ret_valid(ret_valid), .ret_boundary(ret_boundary), .ret_rep(ret_rep),
    .ret_ip(ret_ip), .ret_next_ip(ret_next_ip),
    .nmi_pending(nmi_pending), .nmi_blocked(nmi_blocked), .if_flag(if_flag),
    .irq_valid(irq_valid), .irq_vector(irq_vector),
    .nmi_accept(nmi_accept), .irq_ready(irq_ready),
    .take(take), .take_vector(take_vector), .take_ret_ip(take_ret_ip)
  );

  // R2: entering the blocked state coincides with an NMI vector take
  p_nmi_vec_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nmi_blocked) |-> take && take_vector == VEC_W'(NMI_VECTOR));
  // R4: nothing accepted while blocked
  p_block_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_blocked |-> !irq_ready && !nmi_accept);
  // R4: handler return ends blocking next cycle
  p_unblock_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_done && nmi_blocked |=> !nmi_blocked);
  // R3: maskable acceptance needs the enable flag
  p_mask_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ready |-> if_flag && irq_valid);
endmodule

// File: tb/test_intr_accept_unit.sv
module test_intr_accept_unit;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic irq_valid = 1'b0;
  logic [7:0] irq_vector = '0;
  logic irq_ready;
  logic nmi_pin = 1'b0;
  logic bus_msg_valid = 1'b0;
  logic [2:0] bus_msg_mode = '0;
  logic if_set = 1'b0, if_clr = 1'b0;
  logic ret_valid = 1'b0, ret_boundary = 1'b0, ret_rep = 1'b0;
  logic [31:0] ret_ip = '0, ret_next_ip = '0;
  logic nmi_done = 1'b0;
  logic take;
  logic [7:0] take_vector;
  logic [31:0] take_ret_ip;
  logic if_flag, nmi_blocked;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic rdy_seen;

  always #5 clk = ~clk;

  intr_accept_unit i_intr_accept_unit (
    .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_vector(irq_vector),
    .irq_ready(irq_ready), .nmi_pin(nmi_pin), .bus_msg_valid(bus_msg_valid),
    .bus_msg_mode(bus_msg_mode), .if_set(if_set), .if_clr(if_clr),
    .ret_valid(ret_valid), .ret_boundary(ret_boundary), .ret_rep(ret_rep),
    .ret_ip(ret_ip), .ret_next_ip(ret_next_ip), .nmi_done(nmi_done),
    .take(take), .take_vector(take_vector), .take_ret_ip(take_ret_ip),
    .if_flag(if_flag), .nmi_blocked(nmi_blocked)
  );

  localparam int N = 6;
  localparam logic       T_IF  [N] = '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
  localparam logic       T_REP [N] = '{1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1};
  localparam logic [7:0] T_VEC [N] = '{8'h20, 8'h21, 8'h40, 8'hFF, 8'h55, 8'h03};

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one retirement for a cycle; rdy_seen holds irq_ready of that cycle
  task automatic retire(logic bnd, logic rep, logic [31:0] ip, logic [31:0] nip);
    ret_valid = 1'b1; ret_boundary = bnd; ret_rep = rep;
    ret_ip = ip; ret_next_ip = nip;
    #1;
    rdy_seen = irq_ready;
    step();
    ret_valid = 1'b0; ret_boundary = 1'b0; ret_rep = 1'b0;
  endtask

  task automatic pulse_if(logic en);
    if (en) if_set = 1'b1; else if_clr = 1'b1;
    step();
    if_set = 1'b0; if_clr = 1'b0;
  endtask

  task automatic bus_pulse(logic [2:0] mode);
    bus_msg_valid = 1'b1; bus_msg_mode = mode;
    step();
    bus_msg_valid = 1'b0; bus_msg_mode = '0;
    step();
  endtask

  task automatic done_pulse();
    nmi_done = 1'b1;
    step();
    nmi_done = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) step();
    // R10: reset state
    check("R10 take", {31'd0, take}, 32'd0);
    check("R10 if_flag", {31'd0, if_flag}, 32'd0);
    check("R10 nmi_blocked", {31'd0, nmi_blocked}, 32'd0);
    rst_n = 1'b1;
    step();
    check("R10 take after release", {31'd0, take}, 32'd0);

    // table: maskable gating, vector, return pointer (R3, R5, R6, R9)
    for (int i = 0; i < N; i++) begin
      logic [31:0] ip;
      logic [31:0] nip;
      ip  = 32'h1000 + 32'(i) * 32'h10;
      nip = ip + 32'd4;
      pulse_if(T_IF[i]);
      irq_valid = 1'b1; irq_vector = T_VEC[i];
      retire(1'b1, T_REP[i], ip, nip);
      check("R9 irq_ready", {31'd0, rdy_seen}, {31'd0, T_IF[i]});
      check("R3 take gated", {31'd0, take}, {31'd0, T_IF[i]});
      if (T_IF[i]) begin
        check("R3 vector", {24'd0, take_vector}, {24'd0, T_VEC[i]});
        check("R6 ret ip", take_ret_ip, T_REP[i] ? ip : nip);
      end
      irq_valid = 1'b0;
      step();
      check("R9 single cycle take", {31'd0, take}, 32'd0);
    end

    // R3: clear wins over set
    if_set = 1'b1; if_clr = 1'b1;
    step();
    if_set = 1'b0; if_clr = 1'b0;
    check("R3 clear wins", {31'd0, if_flag}, 32'd0);

    // R1/R2: pin NMI with IF clear
    nmi_pin = 1'b1;
    repeat (4) step();
    retire(1'b1, 1'b0, 32'h2000, 32'h2004);
    check("R1 pin nmi take", {31'd0, take}, 32'd1);
    check("R2 nmi vector", {24'd0, take_vector}, 32'd2);
    check("R6 nmi ret ip", take_ret_ip, 32'h2004);
    check("R4 blocked set", {31'd0, nmi_blocked}, 32'd1);
    nmi_pin = 1'b0;
    step();

    // R4: maskable and further NMIs blocked
    pulse_if(1'b1);
    irq_valid = 1'b1; irq_vector = 8'h30;
    retire(1'b1, 1'b0, 32'h2100, 32'h2104);
    check("R4 no maskable while blocked", {31'd0, rdy_seen | take}, 32'd0);
    bus_pulse(3'b100);
    bus_pulse(3'b100);
    retire(1'b1, 1'b0, 32'h2200, 32'h2204);
    check("R4 no nmi while blocked", {31'd0, take}, 32'd0);
    done_pulse();
    check("R4 unblocked after done", {31'd0, nmi_blocked}, 32'd0);

    // R7/R8: held NMI wins over pending maskable
    retire(1'b1, 1'b1, 32'h2300, 32'h2308);
    check("R8 irq_ready low", {31'd0, rdy_seen}, 32'd0);
    check("R7 held nmi delivered", {31'd0, take}, 32'd1);
    check("R7 held nmi vector", {24'd0, take_vector}, 32'd2);
    check("R6 rep ret ip", take_ret_ip, 32'h2300);
    step();
    done_pulse();
    retire(1'b1, 1'b0, 32'h2400, 32'h2404);
    check("R8 maskable kept", {31'd0, rdy_seen}, 32'd1);
    check("R7 collapsed, maskable vector", {24'd0, take_vector}, 32'h30);
    check("R7 not blocked again", {31'd0, nmi_blocked}, 32'd0);
    irq_valid = 1'b0;
    step();

    // R5: interior retirement never takes
    irq_valid = 1'b1; irq_vector = 8'h77;
    retire(1'b0, 1'b0, 32'h2500, 32'h2504);
    check("R5 no take mid instruction", {31'd0, rdy_seen | take}, 32'd0);
    irq_valid = 1'b0;
    step();

    // R1: bus message with another mode ignored
    bus_pulse(3'b000);
    bus_pulse(3'b110);
    retire(1'b1, 1'b0, 32'h2600, 32'h2604);
    check("R1 other mode ignored", {31'd0, take}, 32'd0);
    check("R1 no block from other mode", {31'd0, nmi_blocked}, 32'd0);

    // R1: bus NMI mode accepted
    bus_pulse(3'b100);
    retire(1'b1, 1'b0, 32'h2700, 32'h2704);
    check("R1 bus nmi take", {31'd0, take}, 32'd1);
    check("R2 bus nmi vector", {24'd0, take_vector}, 32'd2);

    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule